// File: doc/BRIEF.md
# Command/Data Stream Splitter

This block drains one requester's outbound queue. Command words and payload words are interleaved in that queue. The block reads the queue through a first-word-fall-through pop interface, where the head word is visible whenever the queue is not empty. It decodes every command header it finds.

Write headers, and the payload words behind them, leave on a write channel with a valid/ready handshake. A tag on that channel tells headers apart from payload. Read headers are removed from the stream and pushed into a separate read-command queue.

The block counts the writes still outstanding in memory, and a read is held back until that count is zero. A later read therefore never overtakes an earlier write from the same stream. All decisions are combinational on the current head word, so a word can be consumed every cycle.

Top module: `stream_splitter`

## Requirements
- R1: After reset the outstanding-write count and the payload counter are zero. While the input queue is empty, `inPop`, `wrValid` and `rdPush` stay low.
- R2: A command word is laid out as follows. Bit 31 is the direction (1 = write, 0 = read), bits 30:12 are the address and bits 11:0 are the byte count. A write header with a nonzero count appears in the same cycle on `wrWord` with `wrIsCmd`=1. It is popped in the cycle `wrReady` is high.
- R3: A write header with byte count N is followed by ceil(N/4) payload words. Each of them is forwarded with `wrIsCmd`=0. The word after the last of them is decoded as a command.
- R4: While `wrValid` is high and `wrReady` is low, the input is not popped, and `wrValid`, `wrWord` and `wrIsCmd` hold their values.
- R5: A read header with a nonzero count is pushed to the read queue in the same cycle, with address on `rdAddr` and count on `rdBytes`, and popped. It never appears on the write channel.
- R6: Each accepted write header adds one outstanding write, and only a `wrDone` pulse removes one. No read header is pushed while any write is outstanding.
- R7: While `rdFull` is high, a read header at the head is neither pushed nor popped, so nothing is lost.
- R8: A header with a byte count of zero, read or write, is popped in one cycle. It produces no output and adds no outstanding write.
- R9: Read headers that follow one another are pushed one per cycle.
- R10: At most MAX_PEND (default 3) writes may be outstanding. A further write header waits, with `wrValid` low, until a `wrDone` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inEmpty | input | 1 | Input queue empty |
| inData | input | 32 | Head word of the input queue |
| inPop | output | 1 | Consume the head word |
| wrValid | output | 1 | Write channel word valid |
| wrReady | input | 1 | Write channel accepts the word |
| wrIsCmd | output | 1 | 1 = write header, 0 = payload word |
| wrWord | output | 32 | Write channel word |
| wrDone | input | 1 | One write fully committed to memory |
| rdPush | output | 1 | Push a read command |
| rdFull | input | 1 | Read-command queue full |
| rdAddr | output | 19 | Address of the pushed read |
| rdBytes | output | 12 | Byte count of the pushed read |

## Verification
Every output reacts to the current head word and port inputs within the same cycle. Counter effects such as payload countdown, outstanding writes and acknowledge release show up at the next rising edge. The bench therefore drives inputs on the falling edge and compares all outputs one nanosecond later. It advances its behavioural model (a word queue plus two integers) only after the following rising edge, so each comparison sees exactly the state left by the previous edge.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  // Strobes from the control decision logic to the datapath registers
  typedef struct packed {
    logic loadCount;  // write header accepted: load payload word count
    logic decCount;   // payload word accepted
    logic incPend;    // one more write outstanding
  } ctrlStrobes_t;
endpackage

// File: rtl/splitter_datapath.sv
module splitter_datapath
  import splitter_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 12,
  parameter int MAX_PEND = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WORD_W-1:0]           inData,
  input  ctrlStrobes_t                strobes,
  input  logic                        wrDone,
  output logic                        headIsWrite,
  output logic                        headZero,
  output logic                        inDataPhase,
  output logic                        pendFull,
  output logic                        pendClear,
  output logic [WORD_W-1:0]           wrWord,
  output logic                        wrIsCmd,
  output logic [WORD_W-CNT_W-2:0]     rdAddr,
  output logic [CNT_W-1:0]            rdBytes
);
  localparam int ADDR_W = WORD_W - 1 - CNT_W;
  localparam int BPW    = WORD_W / 8;
  localparam int SHIFT  = $clog2(BPW);
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic [CNT_W-1:0]  headCount;
  logic [CNT_W:0]    roundedSum;
  logic [CNT_W-1:0]  wordsNeeded;
  logic [CNT_W-1:0]  dataLeft;
  logic [PEND_W-1:0] pendCnt;
  logic              ackTaken;

  assign headCount   = inData[CNT_W-1:0];
  assign headIsWrite = inData[WORD_W-1];
  assign headZero    = (headCount == '0);
  assign roundedSum  = {1'b0, headCount} + (CNT_W+1)'(BPW - 1);
  assign wordsNeeded = CNT_W'(roundedSum >> SHIFT);

  assign inDataPhase = (dataLeft != '0);
  assign pendFull    = (pendCnt == PEND_W'(MAX_PEND));
  assign pendClear   = (pendCnt == '0);
  assign ackTaken    = wrDone && !pendClear;

  assign wrWord  = inData;
  assign wrIsCmd = !inDataPhase;
  assign rdAddr  = inData[WORD_W-2 -: ADDR_W];
  assign rdBytes = headCount;

  // Payload words still owed by the current write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataLeft <= '0;
    end else if (strobes.loadCount) begin
      dataLeft <= wordsNeeded;
    end else if (strobes.decCount) begin
      dataLeft <= dataLeft - CNT_W'(1);
    end
  end

  // Writes accepted but not yet acknowledged by memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      case ({strobes.incPend, ackTaken})
        2'b10:   pendCnt <= pendCnt + PEND_W'(1);
        2'b01:   pendCnt <= pendCnt - PEND_W'(1);
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assert_payload_countdown_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decCount |=> dataLeft == $past(dataLeft) - CNT_W'(1));

  assert_pend_only_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!pendClear && !strobes.incPend && !wrDone) |=> $stable(pendCnt));

  assert_pend_limit_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incPend |-> !pendFull);
endmodule

// File: rtl/splitter_control.sv
module splitter_control
  import splitter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inEmpty,
  input  logic         wrReady,
  input  logic         rdFull,
  input  logic         headIsWrite,
  input  logic         headZero,
  input  logic         inDataPhase,
  input  logic         pendFull,
  input  logic         pendClear,
  output logic         inPop,
  output logic         wrValid,
  output logic         rdPush,
  output ctrlStrobes_t strobes
);
  always_comb begin
    inPop   = 1'b0;
    wrValid = 1'b0;
    rdPush  = 1'b0;
    strobes = '0;
    if (!inEmpty) begin
      if (inDataPhase) begin
        wrValid          = 1'b1;
        inPop            = wrReady;
        strobes.decCount = wrReady;
      end else if (headZero) begin
        inPop = 1'b1;
      end else if (headIsWrite) begin
        wrValid           = !pendFull;
        inPop             = !pendFull && wrReady;
        strobes.loadCount = inPop;
        strobes.incPend   = inPop;
      end else begin
        rdPush = pendClear && !rdFull;
        inPop  = rdPush;
      end
    end
  end

  assert_pop_needs_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    inPop |-> !inEmpty);

  assert_full_stalls_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!inEmpty && !inDataPhase && !headIsWrite && !headZero && rdFull) |-> !inPop);
endmodule

// File: rtl/stream_splitter.sv
module stream_splitter
  import splitter_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 12,
  parameter int MAX_PEND = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inEmpty,
  input  logic [WORD_W-1:0]       inData,
  output logic                    inPop,
  output logic                    wrValid,
  input  logic                    wrReady,
  output logic                    wrIsCmd,
  output logic [WORD_W-1:0]       wrWord,
  input  logic                    wrDone,
  output logic                    rdPush,
  input  logic                    rdFull,
  output logic [WORD_W-CNT_W-2:0] rdAddr,
  output logic [CNT_W-1:0]        rdBytes
);
  ctrlStrobes_t strobes;
  logic headIsWrite, headZero, inDataPhase, pendFull, pendClear;

  splitter_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W), .MAX_PEND(MAX_PEND)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strobes(strobes), .wrDone(wrDone),
    .headIsWrite(headIsWrite), .headZero(headZero), .inDataPhase(inDataPhase),
    .pendFull(pendFull), .pendClear(pendClear), .wrWord(wrWord), .wrIsCmd(wrIsCmd),
    .rdAddr(rdAddr), .rdBytes(rdBytes)
  );

  splitter_control u_ctl (
    .clk(clk), .rstN(rstN), .inEmpty(inEmpty), .wrReady(wrReady), .rdFull(rdFull),
    .headIsWrite(headIsWrite), .headZero(headZero), .inDataPhase(inDataPhase),
    .pendFull(pendFull), .pendClear(pendClear), .inPop(inPop), .wrValid(wrValid),
    .rdPush(rdPush), .strobes(strobes)
  );

  assert_hold_while_stalled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid && $stable(wrWord) && $stable(wrIsCmd));

  assert_single_destination_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPush && wrValid));

  assert_read_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdPush |-> pendClear);
endmodule

// File: tb/stream_splitter_tb.sv
module stream_splitter_tb;
  localparam int MAXP = 3;

  logic clk = 1'b0;
  logic rstN, inEmpty, inPop, wrValid, wrReady, wrIsCmd, wrDone, rdPush, rdFull;
  logic [31:0] inData, wrWord;
  logic [18:0] rdAddr;
  logic [11:0] rdBytes;

  always #10 clk = ~clk;

  stream_splitter u_dut (
    .clk(clk), .rstN(rstN), .inEmpty(inEmpty), .inData(inData), .inPop(inPop),
    .wrValid(wrValid), .wrReady(wrReady), .wrIsCmd(wrIsCmd), .wrWord(wrWord),
    .wrDone(wrDone), .rdPush(rdPush), .rdFull(rdFull), .rdAddr(rdAddr), .rdBytes(rdBytes)
  );

  logic [31:0] stream[$];
  int mDl = 0, mPend = 0, cycles = 0, tests = 0, fails = 0;
  bit mPrevRead = 0, timedOut = 0, ackEn = 1;
  int unsigned readyPct = 100, fullPct = 0, ackPct = 100;

  function automatic logic [31:0] hdr(bit w, int addr, int bytes);
    return {w, 19'(addr), 12'(bytes)};
  endfunction

  task automatic addWrite(int addr, int bytes);
    stream.push_back(hdr(1'b1, addr, bytes));
    for (int i = 0; i < (bytes + 3) / 4; i++) stream.push_back($urandom);
  endtask

  task automatic addRead(int addr, int bytes);
    stream.push_back(hdr(1'b0, addr, bytes));
  endtask

  task automatic step();
    logic [31:0] h;
    logic eWv, ePush, ePop, eCmd;
    logic [66:0] expV, actV;
    bit isW;
    int c;
    string req;
    @(negedge clk);
    inEmpty = (stream.size() == 0);
    inData  = inEmpty ? 32'h0 : stream[0];
    wrReady = (($urandom % 100) < readyPct);
    rdFull  = (($urandom % 100) < fullPct);
    wrDone  = ackEn && (mPend > 0) && (($urandom % 100) < ackPct);
    #1;
    h = inData; isW = h[31]; c = int'(h[11:0]);
    eWv = 0; ePush = 0; ePop = 0; eCmd = 0; req = "R1";
    if (!inEmpty) begin
      if (mDl > 0) begin
        eWv = 1; ePop = wrReady; req = wrReady ? "R3" : "R4";
      end else if (c == 0) begin
        ePop = 1; req = "R8";
      end else if (isW) begin
        eCmd = 1;
        if (mPend >= MAXP) req = "R10";
        else begin eWv = 1; ePop = wrReady; req = wrReady ? "R2" : "R4"; end
      end else begin
        ePush = (mPend == 0) && !rdFull; ePop = ePush;
        req = (mPend > 0) ? "R6" : rdFull ? "R7" : mPrevRead ? "R9" : "R5";
      end
    end
    expV = {eWv, ePush, ePop, eWv & eCmd, eWv ? h : 32'h0, ePush ? h[30:0] : 31'h0};
    actV = {wrValid, rdPush, inPop, wrValid & wrIsCmd, wrValid ? wrWord : 32'h0,
            rdPush ? {rdAddr, rdBytes} : 31'h0};
    tests++;
    if (actV !== expV) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cycles, actV, expV);
    end
    @(posedge clk);
    cycles++;
    if (cycles > 150000) timedOut = 1;
    mPrevRead = ePush;
    if (ePop) begin
      void'(stream.pop_front());
      if (mDl > 0) mDl--;
      else if (isW && c != 0) begin mDl = (c + 3) / 4; mPend++; end
    end
    if (wrDone && mPend > 0) mPend--;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    while ((stream.size() != 0 || mPend != 0) && !timedOut) step();
  endtask

  initial begin
    rstN = 0; inEmpty = 1; inData = 0; wrReady = 0; rdFull = 0; wrDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    runCycles(3);                                    // R1 idle after reset
    addRead(5, 16); addRead(6, 1); addRead(7, 4095); // R5, R9
    drain();
    addWrite(100, 5); addWrite(200, 8); addWrite(300, 1); // R2, R3
    drain();
    ackEn = 0; addWrite(400, 8); addRead(401, 4);   // R6: read held
    runCycles(12); ackEn = 1; drain();
    addWrite(500, 0); addRead(501, 0); addRead(502, 3); // R8
    drain();
    ackEn = 0; for (int i = 0; i < 4; i++) addWrite(600 + i, 4); // R10
    runCycles(20); ackEn = 1; drain();
    addWrite(700, 13);
    drain();
    readyPct = 50; fullPct = 50; ackPct = 30;        // R4, R7 under random stalls
    for (int i = 0; i < 40; i++) begin
      int k = int'($urandom % 4);
      if (k == 0) addRead(int'($urandom % 512), int'($urandom % 64));
      else if (k == 1) addRead(int'($urandom % 512), 0);
      else addWrite(int'($urandom % 512), int'($urandom % 40));
    end
    drain();
    if (timedOut) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected drained stream");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule